// File: doc/BRIEF.md
# Unlock-Gated Serial Configuration Loader

This block accepts configuration words over a two-wire serial link (a serial clock and a serial data line) that the system may also use for other purposes. Both wires are asynchronous to the fast system clock and are synchronised on entry. Nothing is written while the link is locked. A preamble of repeated clock pulses with data held high, closed by one pulse with data low, arms the loader. The loader then decodes a framed word in which every bit travels twice: first inverted, sampled on the serial clock falling edge, then true, sampled on the following rising edge.

A complete frame carries a start bit, 24 payload bits and a stop marker. The payload holds 21 data bits followed by a 3-bit register address. A valid stop produces a single-cycle write strobe with address and data toward one of six destination registers. Malformed frames drive an active-low error flag. A watchdog restarted by every line transition drops a stalled transfer, and power-down refuses to arm the loader.

Top module: `serial_cfg_loader`

## Requirements
- R1: The loader arms only when at least UNLOCK_MIN (default 5) consecutive serial-clock rising edges with data high are followed directly by a rising edge with data low; fewer high edges leave it locked, and the frame that follows produces no write.
- R2: Each frame bit is a pair: data sampled at a serial-clock falling edge must be the inverse of data sampled at the next rising edge, and the rising-edge value is the bit; a non-inverted pair (other than the stop) is an error.
- R3: The first pair after arming is the start bit with value 0 (a start value of 1 is an error). The next 24 bits arrive least significant first: the first 21 form data bits 0..20, and the last 3 form address bits 0..2.
- R4: Exactly 24 payload bits must precede the stop; a stop after 23 bits, or an extra complementary bit in place of the stop, is an error and produces no write.
- R5: The stop is data high at both the falling and the rising edge. A valid stop drives wr_en_o high for exactly one system cycle with the received address and data, and the loader returns to the locked state.
- R6: Legal addresses are 000, 001, 010, 011, 100 and 110; a stop carrying 101 or 111 is an error and produces no write.
- R7: If no transition occurs on either serial wire for WDOG_CYCLES system cycles, a partly received frame is discarded without an error and the loader relocks; gaps shorter than that do not disturb a transfer.
- R8: While pwr_down_i is high the loader cannot arm, and raising it during a frame abandons that frame; no write results.
- R9: err_n_o is driven low by any frame error and stays low until the next successful arming, which drives it high again; no write coincides with an error.
- R10: After reset, err_n_o is 1 and wr_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock wire |
| ser_data_i | input | 1 | Asynchronous serial data wire |
| pwr_down_i | input | 1 | High while the device is powered down |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 3 | Destination register address |
| wr_data_o | output | 21 | Data written to the register |
| err_n_o | output | 1 | Frame error flag, active low |

## Verification
Valid frames go to every legal address with alternating, all-ones, all-zero and mixed data, so that bit order and address placement are checked separately. Preambles of exactly five and of seven high pulses pass, and a four-pulse preamble does not. Separate malformed frames target each error cause in isolation: a wrong start value, one non-inverted pair, a short frame, a long frame and each illegal address. The error flag is checked to clear on the following good frame. Stalls just below and above the watchdog window, plus a frame sent during power-down, tell apart a transfer that pauses from one that must be dropped.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int DATA_W     = 21;
    localparam int ADDR_W     = 3;
    localparam int FRAME_BITS = DATA_W + ADDR_W;
    localparam int IDX_W      = $clog2(FRAME_BITS + 2);

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_FRAME  = 1'b1
    } ldr_state_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_is_legal(input logic [ADDR_W-1:0] a);
        return (a != 3'b101) && (a != 3'b111);
    endfunction

    function automatic logic [FRAME_BITS-1:0] shift_in(
        input logic [FRAME_BITS-1:0] sr,
        input logic                  b
    );
        return {b, sr[FRAME_BITS-1:1]};
    endfunction

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              hold;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                hold  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[b]};
                hold  <= chain[LAST];
            end
        end
        assign lvl_o[b]  = chain[LAST];
        assign prev_o[b] = hold;
    end

endmodule

// File: rtl/scl_watchdog.sv
module scl_watchdog #(
    parameter int LIMIT = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic activity_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (activity_i) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired_o = (cnt == CW'(LIMIT)) && !activity_i;

endmodule

// File: rtl/scl_frame.sv
module scl_frame
    import scl_pkg::*;
#(
    parameter int UNLOCK_MIN = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_rise_i,
    input  logic    sclk_fall_i,
    input  logic    sdata_i,
    input  logic    wd_expired_i,
    input  logic    pwr_down_i,
    output wr_req_t wr_o,
    output logic    err_n_o
);
    localparam int HW = $clog2(UNLOCK_MIN + 1);

    ldr_state_t             st;
    logic [HW-1:0]          hi_cnt;
    logic [IDX_W-1:0]       idx;
    logic                   fall_val;
    logic [FRAME_BITS-1:0]  sr;
    wr_req_t                wr_q;
    logic                   err_n_q;

    logic [ADDR_W-1:0] rx_addr;
    logic [DATA_W-1:0] rx_data;
    logic              pair_inv;
    logic              pair_stop;

    assign rx_addr   = sr[FRAME_BITS-1:DATA_W];
    assign rx_data   = sr[DATA_W-1:0];
    assign pair_inv  = fall_val != sdata_i;
    assign pair_stop = fall_val && sdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_LOCKED;
            hi_cnt   <= '0;
            idx      <= '0;
            fall_val <= 1'b0;
            sr       <= '0;
            wr_q     <= '0;
            err_n_q  <= 1'b1;
        end else begin
            wr_q.en <= 1'b0;
            if (wd_expired_i) begin
                st     <= ST_LOCKED;
                hi_cnt <= '0;
            end else begin
                unique case (st)
                    ST_LOCKED: begin
                        if (sclk_rise_i) begin
                            if (sdata_i) begin
                                if (hi_cnt != HW'(UNLOCK_MIN))
                                    hi_cnt <= hi_cnt + 1'b1;
                            end else begin
                                hi_cnt <= '0;
                                if (hi_cnt == HW'(UNLOCK_MIN) && !pwr_down_i) begin
                                    st      <= ST_FRAME;
                                    idx     <= '0;
                                    err_n_q <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_FRAME: begin
                        if (pwr_down_i) begin
                            st <= ST_LOCKED;
                        end else if (sclk_fall_i) begin
                            fall_val <= sdata_i;
                        end else if (sclk_rise_i) begin
                            if (idx == '0) begin
                                if (pair_inv && !sdata_i) begin
                                    idx <= idx + 1'b1;
                                end else begin
                                    err_n_q <= 1'b0;
                                    st      <= ST_LOCKED;
                                end
                            end else if (idx <= IDX_W'(FRAME_BITS)) begin
                                if (pair_inv) begin
                                    sr  <= shift_in(sr, sdata_i);
                                    idx <= idx + 1'b1;
                                end else begin
                                    err_n_q <= 1'b0;
                                    st      <= ST_LOCKED;
                                end
                            end else begin
                                st <= ST_LOCKED;
                                if (pair_stop && addr_is_legal(rx_addr)) begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.addr <= rx_addr;
                                    wr_q.data <= rx_data;
                                end else begin
                                    err_n_q <= 1'b0;
                                end
                            end
                        end
                    end
                    default: st <= ST_LOCKED;
                endcase
            end
        end
    end

    assign wr_o    = wr_q;
    assign err_n_o = err_n_q;

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import scl_pkg::*;
#(
    parameter int UNLOCK_MIN  = 5,
    parameter int WDOG_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              pwr_down_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              err_n_o
);
    localparam int PIN_CLK  = 0;
    localparam int PIN_DATA = 1;

    logic [1:0] lvl, prev, rise, fall;
    logic       wd_expired;
    wr_req_t    wr;

    scl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_data_i, ser_clk_i}),
        .lvl_o   (lvl),
        .prev_o  (prev)
    );

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    scl_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk        (clk),
        .rst        (rst),
        .activity_i (|(rise | fall)),
        .expired_o  (wd_expired)
    );

    scl_frame #(.UNLOCK_MIN(UNLOCK_MIN)) u_frame (
        .clk          (clk),
        .rst          (rst),
        .sclk_rise_i  (rise[PIN_CLK]),
        .sclk_fall_i  (fall[PIN_CLK]),
        .sdata_i      (lvl[PIN_DATA]),
        .wd_expired_i (wd_expired),
        .pwr_down_i   (pwr_down_i),
        .wr_o         (wr),
        .err_n_o      (err_n_o)
    );

    assign wr_en_o   = wr.en;
    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;

endmodule

// File: rtl/scl_checker.sv
module scl_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_down_i,
    input logic       wr_en_o,
    input logic [2:0] wr_addr_o,
    input logic       err_n_o
);
    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

    // R6
    legal_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_addr_o != 3'b101 && wr_addr_o != 3'b111));

    // R8
    no_write_pd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> !$past(pwr_down_i));

    // R9
    write_clean_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> err_n_o);

    // R9
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n_o) |-> !wr_en_o);

endmodule

bind serial_cfg_loader scl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_down_i (pwr_down_i),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .err_n_o    (err_n_o)
);

// File: tb/tb_serial_cfg_loader.sv
module tb_serial_cfg_loader;

    localparam int H    = 6;
    localparam int WDOG = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        sdat = 1'b1;
    logic        pd = 1'b0;
    logic        wr_en_o;
    logic [2:0]  wr_addr_o;
    logic [20:0] wr_data_o;
    logic        err_n_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] exp_q[$];

    always #4 clk = ~clk;

    serial_cfg_loader #(.UNLOCK_MIN(5), .WDOG_CYCLES(WDOG)) dut (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdat),
        .pwr_down_i(pd), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .err_n_o(err_n_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes (R3, R5)
    always @(negedge clk) begin
        if (!rst && wr_en_o) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected write", {8'h0, wr_addr_o, wr_data_o}, 32'hFFFFFFFF);
            end else begin
                check("R3 write addr/data", {8'h0, wr_addr_o, wr_data_o}, {8'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic dfall, input logic drise);
        sdat = dfall; wait_cyc(H);
        sclk = 1'b0;  wait_cyc(H);
        sdat = drise; wait_cyc(H);
        sclk = 1'b1;  wait_cyc(H);
    endtask

    task automatic send_frame(input logic [2:0] a, input logic [20:0] d, input int n_hi,
                              input int n_bits, input int bad_at, input logic start_val,
                              input logic expect_wr);
        logic [23:0] v;
        v = {a, d};
        if (expect_wr) exp_q.push_back(v);
        for (int i = 0; i < n_hi; i++) pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b0);
        pulse(~start_val, start_val);
        for (int i = 0; i < n_bits; i++) begin
            logic b;
            b = (i < 24) ? v[i] : 1'b0;
            if (i == bad_at) pulse(1'b0, 1'b0);
            else pulse(~b, b);
        end
        pulse(1'b1, 1'b1);
        wait_cyc(10);
    endtask

    task automatic good(input logic [2:0] a, input logic [20:0] d, input string tag);
        send_frame(a, d, 5, 24, -1, 1'b0, 1'b1);
        check({tag, " write seen"}, exp_q.size(), 0);
        check({tag, " err_n high"}, err_n_o, 1);
    endtask

    task automatic bad(input logic [2:0] a, input int n_bits, input int bad_at,
                       input logic start_val, input string tag);
        send_frame(a, 21'h155555, 5, n_bits, bad_at, start_val, 1'b0);
        check({tag, " err_n low"}, err_n_o, 0);
        wait_cyc(WDOG + 100);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        // R10
        check("R10 reset err_n", err_n_o, 1);
        check("R10 reset wr_en", wr_en_o, 0);

        // R3 R5 R6: legal addresses, varied data
        good(3'b000, 21'h155555, "R3 a0");
        good(3'b001, 21'h0AAAAA, "R3 a1");
        good(3'b010, 21'h1FFFFF, "R6 a2");
        good(3'b011, 21'h000000, "R6 a3");
        good(3'b100, 21'h012345, "R6 a4");
        good(3'b110, 21'h0F0F0F, "R6 a6");

        // R1: longer preamble accepted
        send_frame(3'b001, 21'h13579B, 7, 24, -1, 1'b0, 1'b1);
        check("R1 seven highs write", exp_q.size(), 0);

        // R6 illegal addresses
        bad(3'b101, 24, -1, 1'b0, "R6 addr 101");
        good(3'b000, 21'h054321, "R9 clear");
        bad(3'b111, 24, -1, 1'b0, "R6 addr 111");

        // R2 pair mismatch, R3 bad start, R4 short/long
        bad(3'b010, 24, 3, 1'b0, "R2 mismatch");
        bad(3'b010, 24, -1, 1'b1, "R3 start one");
        bad(3'b010, 23, -1, 1'b0, "R4 short");
        bad(3'b010, 25, -1, 1'b0, "R4 long");
        good(3'b011, 21'h1A2B3C, "R9 recover");

        // R1: four highs does not arm
        send_frame(3'b000, 21'h0AAAAA, 4, 24, -1, 1'b0, 1'b0);
        wait_cyc(WDOG + 100);
        check("R1 four highs no write", exp_q.size(), 0);
        check("R1 four highs err_n", err_n_o, 1);

        // R8 power-down refuses
        pd = 1'b1;
        send_frame(3'b000, 21'h0AAAAA, 5, 24, -1, 1'b0, 1'b0);
        pd = 1'b0;
        wait_cyc(WDOG + 100);
        check("R8 pd err_n", err_n_o, 1);

        // R7 stall above window drops the frame
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) pulse(i[0], ~i[0]);
        wait_cyc(WDOG + 100);
        check("R7 timeout err_n", err_n_o, 1);
        good(3'b100, 21'h0C0FFE, "R7 after timeout");

        // R7 stall below window keeps the frame
        exp_q.push_back({3'b010, 21'h1E1E1E});
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 24; i++) begin
            logic [23:0] v;
            v = {3'b010, 21'h1E1E1E};
            pulse(~v[i], v[i]);
            if (i == 11) wait_cyc(WDOG - 60);
        end
        pulse(1'b1, 1'b1);
        wait_cyc(10);
        check("R7 short stall write seen", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule